// File: doc/BRIEF.md
# Complex Bin Magnitude Streamer

This block sits on a streaming path between a transform engine and a memory write channel. Each input beat carries one complex spectral bin. The bin is packed as two signed halves in one word. For each bin the block produces the magnitude sqrt(re² + im²) as an IEEE-754 single-precision word. Software can then read the destination buffer directly as an array of floats. The phase is discarded, so only amplitudes leave the block.

Both sides use a valid/ready/data/last stream handshake. The block emits exactly one output beat for every input beat, in arrival order. The end-of-frame flag travels with its own bin. A nominal frame is 4096 bins, but the block never counts bins and accepts frames of any length.

Internally the datapath is a chain of identical hand-off slots. The first slot forms the sum of squares. One slot per result bit then performs a digit-by-digit restoring integer square root. The last slot converts the integer root to float without rounding. Each slot is governed by a two-state controller:
- EMPTY goes to FULL when an upstream beat is loaded.
- FULL goes to EMPTY when downstream takes the beat and no new beat arrives.
- FULL stays FULL while it is stalled or being refilled in the same cycle.

Top module: `bin_mag_stream`

## Requirements
- R1: The input word holds the real part in bits [15:0] and the imaginary part in bits [31:16]. Both are signed two's complement, so 0x0000FFFF is re = −1, im = 0, with magnitude 1.
- R2: The output value is floor(sqrt(re² + im²)), converted exactly. For example, re = im = 2 gives 2.0 (0x40000000), and re = im = −32768 gives 46340.0 (0x47350400).
- R3: A zero bin (re = im = 0) gives exactly +0.0, which is 0x00000000.
- R4: For a non-zero root, the output has sign bit 31 = 0. The exponent field in bits [30:23] is 127 plus the position of the root's leading one. Bits [22:0] hold the remaining root bits left-aligned, with no rounding. For example, 5 gives 0x40A00000.
- R5: Every accepted input beat produces exactly one output beat, in the same order, with nothing dropped or duplicated under any pattern of output ready.
- R6: The output last flag is high exactly on the output beat of the bin that was accepted with input last high.
- R7: While the output valid is high and the output ready is low, the output valid, data and last hold their values.
- R8: When the pipeline holds DEPTH = HALF_W + 2 unaccepted bins and the output ready is low, the input ready is low.
- R9: With the output ready held high, one bin is accepted and one is emitted on every clock. The output handshake of a bin comes exactly DEPTH cycles after its input handshake.
- R10: A synchronous active-low reset empties every slot. After reset the output valid and last are low, and the input ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input bin is present |
| in_ready | output | 1 | Block can take an input bin this cycle |
| in_data | input | 2*HALF_W | Packed bin: imaginary in the upper half, real in the lower half |
| in_last | input | 1 | Input bin is the final bin of its frame |
| out_valid | output | 1 | Magnitude word is present |
| out_ready | input | 1 | Downstream takes the magnitude word this cycle |
| out_data | output | 32 | Magnitude as single-precision float |
| out_last | output | 1 | Magnitude belongs to the final bin of its frame |

## Verification
The bench builds the block with its default HALF_W = 16, which gives a 16-step root chain and DEPTH = 18. At this width the bench can drive the most negative halves, whose sum of squares sets bit 31 of the 32-bit sum. It can also drive roots that reach bit 15, which places the exponent at its largest value of 142. With the shallow 18-slot pipeline, the bench can fill the whole pipeline under a held-low output ready and count exactly how many bins get in. A full 4096-bin frame is streamed under pseudo-random backpressure so that the single end-of-frame flag is checked against heavy stall activity.

// File: rtl/mag_pkg.sv
package mag_pkg;

    localparam int F32_BIAS  = 127;
    localparam int F32_EXP_W = 8;
    localparam int F32_MAN_W = 23;
    localparam int F32_W     = 1 + F32_EXP_W + F32_MAN_W;

    // occupancy of one hand-off slot
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

    typedef struct packed {
        logic                 sign;
        logic [F32_EXP_W-1:0] expo;
        logic [F32_MAN_W-1:0] frac;
    } f32_t;

endpackage

// File: rtl/mag_slot_ctrl.sv
// Two-state hand-off controller shared by every pipeline slot.
module mag_slot_ctrl
    import mag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_valid,
    output logic up_ready,
    input  logic up_last,
    output logic dn_valid,
    input  logic dn_ready,
    output logic dn_last,
    output logic load
);

    slot_e slot_q, slot_d;
    logic  last_q;

    assign up_ready = (slot_q == SLOT_EMPTY) || dn_ready;
    assign load     = up_ready && up_valid;
    assign dn_valid = (slot_q == SLOT_FULL);
    assign dn_last  = last_q;

    // transition logic
    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_EMPTY: if (up_valid)              slot_d = SLOT_FULL;
            SLOT_FULL:  if (dn_ready && !up_valid) slot_d = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_EMPTY;
            last_q <= 1'b0;
        end else begin
            slot_q <= slot_d;
            if (load) last_q <= up_last;
        end
    end

endmodule

// File: rtl/mag_square_stage.sv
// Unpacks the signed halves and registers re^2 + im^2.
module mag_square_stage
    import mag_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W,
    localparam int SUM_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_last,
    input  logic [WORD_W-1:0] up_word,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_last,
    output logic [SUM_W-1:0]  dn_sum
);

    logic              load;
    logic [WORD_W-1:0] re_x, im_x, re_sq, im_sq;
    logic [SUM_W-1:0]  sum_d, sum_q;

    mag_slot_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (up_valid),
        .up_ready (up_ready),
        .up_last  (up_last),
        .dn_valid (dn_valid),
        .dn_ready (dn_ready),
        .dn_last  (dn_last),
        .load     (load)
    );

    // sign-extend each half to full word width before squaring
    assign re_x  = {{HALF_W{up_word[HALF_W-1]}}, up_word[HALF_W-1:0]};
    assign im_x  = {{HALF_W{up_word[WORD_W-1]}}, up_word[WORD_W-1:HALF_W]};
    // each square is at most 2^(2*HALF_W-2): low bits of the product are exact
    assign re_sq = re_x * re_x;
    assign im_sq = im_x * im_x;
    assign sum_d = re_sq + im_sq;

    always_ff @(posedge clk) begin
        if (load) sum_q <= sum_d;
    end

    assign dn_sum = sum_q;

endmodule

// File: rtl/mag_root_step.sv
// One restoring square-root digit: decides result bit BITPOS.
module mag_root_step
    import mag_pkg::*;
#(
    parameter int SUM_W  = 32,
    parameter int ROOT_W = 16,
    parameter int BITPOS = 0,
    localparam int TRY_W = SUM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_last,
    input  logic [SUM_W-1:0]  up_rem,
    input  logic [ROOT_W-1:0] up_root,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_last,
    output logic [SUM_W-1:0]  dn_rem,
    output logic [ROOT_W-1:0] dn_root
);

    logic              load;
    logic [TRY_W-1:0]  trial;
    logic              take;
    logic [SUM_W-1:0]  rem_d, rem_q;
    logic [ROOT_W-1:0] root_d, root_q;

    mag_slot_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (up_valid),
        .up_ready (up_ready),
        .up_last  (up_last),
        .dn_valid (dn_valid),
        .dn_ready (dn_ready),
        .dn_last  (dn_last),
        .load     (load)
    );

    // (q + 2^b)^2 - q^2 = q*2^(b+1) + 2^(2b); q has no bits at or below b
    assign trial  = (TRY_W'(up_root) << (BITPOS + 1)) | (TRY_W'(1) << (2 * BITPOS));
    assign take   = {1'b0, up_rem} >= trial;
    assign rem_d  = take ? (up_rem - trial[SUM_W-1:0]) : up_rem;
    assign root_d = up_root | (ROOT_W'(take) << BITPOS);

    always_ff @(posedge clk) begin
        if (load) begin
            rem_q  <= rem_d;
            root_q <= root_d;
        end
    end

    assign dn_rem  = rem_q;
    assign dn_root = root_q;

endmodule

// File: rtl/mag_to_float.sv
// Exact unsigned-integer to single-precision conversion (ROOT_W <= 24).
module mag_to_float
    import mag_pkg::*;
#(
    parameter int ROOT_W = 16,
    localparam int POS_W   = $clog2(ROOT_W) + 1,
    localparam int ALIGN_W = F32_MAN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_last,
    input  logic [ROOT_W-1:0] up_root,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_last,
    output logic [F32_W-1:0]  dn_word
);

    logic               load;
    logic [POS_W-1:0]   lead;
    logic [ALIGN_W-1:0] aligned;
    f32_t               flt_d, flt_q;

    mag_slot_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (up_valid),
        .up_ready (up_ready),
        .up_last  (up_last),
        .dn_valid (dn_valid),
        .dn_ready (dn_ready),
        .dn_last  (dn_last),
        .load     (load)
    );

    // leading-one search: highest set bit wins
    always_comb begin
        lead = '0;
        for (int b = 0; b < ROOT_W; b++) begin
            if (up_root[b]) lead = POS_W'(b);
        end
    end

    assign aligned = ALIGN_W'(up_root) << (F32_MAN_W - int'(lead));

    always_comb begin
        flt_d.sign = 1'b0;
        if (up_root == '0) begin
            flt_d.expo = '0;
            flt_d.frac = '0;
        end else begin
            flt_d.expo = F32_EXP_W'(F32_BIAS) + F32_EXP_W'(lead);
            flt_d.frac = aligned[F32_MAN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (load) flt_q <= flt_d;
    end

    assign dn_word = flt_q;

endmodule

// File: rtl/bin_mag_stream.sv
// Complex bin -> float32 magnitude, one bin per clock, full backpressure.
module bin_mag_stream
    import mag_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W,
    localparam int SUM_W  = 2 * HALF_W,
    localparam int ROOT_W = HALF_W,
    localparam int DEPTH  = ROOT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [F32_W-1:0]  out_data,
    output logic              out_last
);

    // index 0: square stage output; index k+1: output of root step k
    logic [ROOT_W:0]   vld;
    logic [ROOT_W:0]   rdy;
    logic [ROOT_W:0]   lst;
    logic [SUM_W-1:0]  rem  [ROOT_W+1];
    logic [ROOT_W-1:0] root [ROOT_W+1];

    assign root[0] = '0;

    mag_square_stage #(.HALF_W(HALF_W)) u_square (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_last  (in_last),
        .up_word  (in_data),
        .dn_valid (vld[0]),
        .dn_ready (rdy[0]),
        .dn_last  (lst[0]),
        .dn_sum   (rem[0])
    );

    for (genvar k = 0; k < ROOT_W; k++) begin : g_root
        mag_root_step #(
            .SUM_W  (SUM_W),
            .ROOT_W (ROOT_W),
            .BITPOS (ROOT_W - 1 - k)
        ) u_step (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_valid (vld[k]),
            .up_ready (rdy[k]),
            .up_last  (lst[k]),
            .up_rem   (rem[k]),
            .up_root  (root[k]),
            .dn_valid (vld[k+1]),
            .dn_ready (rdy[k+1]),
            .dn_last  (lst[k+1]),
            .dn_rem   (rem[k+1]),
            .dn_root  (root[k+1])
        );
    end

    mag_to_float #(.ROOT_W(ROOT_W)) u_float (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (vld[ROOT_W]),
        .up_ready (rdy[ROOT_W]),
        .up_last  (lst[ROOT_W]),
        .up_root  (root[ROOT_W]),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_last  (out_last),
        .dn_word  (out_data)
    );

endmodule

// File: rtl/mag_checker.sv
module mag_checker #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W,
    localparam int ROOT_W = HALF_W,
    localparam int DEPTH  = ROOT_W + 2,
    localparam int OCC_W  = $clog2(DEPTH + 1) + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] in_data,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [31:0]       out_data,
    input logic              out_last
);

    logic             in_fire, out_fire;
    logic [OCC_W-1:0] occ;
    logic             rst_seen_q;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    // bins accepted but not yet emitted
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ + OCC_W'(in_fire) - OCC_W'(out_fire);
    end

    always_ff @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            assert_reset_clear_R10: assert (!out_valid && !out_last);
        end
        rst_seen_q <= !rst_n;
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));

    assert_no_phantom_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> occ != '0);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    assert_full_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(DEPTH)) && !out_ready |-> !in_ready);

    assert_sign_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_data[31]);

    assert_exp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_data != 32'd0) |->
            (out_data[30:23] >= 8'd127) && (out_data[30:23] < 8'(127 + ROOT_W)));

    assert_zero_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_data[30:23] == 8'd0) |-> out_data == 32'd0);

endmodule

bind bin_mag_stream mag_checker #(.HALF_W(HALF_W)) u_mag_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/tb_bin_mag_stream.sv
module tb_bin_mag_stream;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_W     = 16;
    localparam int WORD_W     = 2 * HALF_W;
    localparam int DEPTH      = HALF_W + 2;
    localparam int FRAME      = 4096;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [WORD_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [31:0]       out_data;
    logic              out_last;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int rdy_mode = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    logic [31:0] dgen = 32'h1234_5678;

    logic [32:0] exp_q[$];
    logic [31:0] out_log[$];
    int out_cnt = 0;
    int last_cnt = 0;
    int last_idx = -1;
    int first_in_cyc = -1;
    int first_out_cyc = -1;
    int last_out_cyc = -1;
    logic        held = 1'b0;
    logic [31:0] held_data = '0;
    logic        held_last = 1'b0;
    bit          done = 1'b0;

    bin_mag_stream #(.HALF_W(HALF_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // independent reference: bisection root, then float packing
    function automatic logic [31:0] ref_mag(input logic [31:0] w);
        longint re, im, s, lo, hi, mid;
        int p;
        logic [63:0] r;
        re = longint'($signed(w[15:0]));
        im = longint'($signed(w[31:16]));
        s  = re * re + im * im;
        lo = 0;
        hi = 65536;
        while (hi - lo > 1) begin
            mid = (lo + hi) / 2;
            if (mid * mid <= s) lo = mid;
            else                hi = mid;
        end
        r = 64'(lo);
        if (r == 0) return 32'd0;
        p = 0;
        for (int b = 0; b < 24; b++) if (r[b]) p = b;
        return {1'b0, 8'(127 + p), 23'((r << (23 - p)) & 64'h7F_FFFF)};
    endfunction

    // output-ready pattern generator
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        case (rdy_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = lfsr[3] | lfsr[7];
            default: out_ready = 1'b0;
        endcase
    end

    // monitor and scoreboard, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (held) begin
                check(out_valid === 1'b1 && out_data === held_data && out_last === held_last,
                      "R7 stalled output changed", {31'd0, out_last, out_data}, {31'd0, held_last, held_data});
            end
            held      = out_valid && !out_ready;
            held_data = out_data;
            held_last = out_last;

            if (in_valid && in_ready) begin
                exp_q.push_back({in_last, ref_mag(in_data)});
                if (first_in_cyc < 0) first_in_cyc = cyc;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 output without pending input", {32'd0, out_data}, 64'd0);
                end else begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    check(out_data === e[31:0], (e[31:0] == 0) ? "R3 zero magnitude" : "R2 magnitude",
                          {32'd0, out_data}, {32'd0, e[31:0]});
                    check(out_last === e[32], "R6 last flag", {63'd0, out_last}, {63'd0, e[32]});
                end
                out_log.push_back(out_data);
                if (out_last) begin
                    last_cnt++;
                    last_idx = out_cnt;
                end
                out_cnt++;
                if (first_out_cyc < 0) first_out_cyc = cyc;
                last_out_cyc = cyc;
            end
        end
    end

    task automatic clear_marks();
        out_log.delete();
        out_cnt = 0;
        last_cnt = 0;
        last_idx = -1;
        first_in_cyc = -1;
        first_out_cyc = -1;
        last_out_cyc = -1;
    endtask

    task automatic send_word(input logic [31:0] w, input bit l);
        in_data  = w;
        in_last  = l;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (exp_q.size() != 0 && guard < 20000) begin
            @(posedge clk);
            guard++;
        end
        check(exp_q.size() == 0, "R5 bins left undelivered", 64'(exp_q.size()), 64'd0);
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R10 out_valid after reset", {63'd0, out_valid}, 64'd0);
        check(out_last === 1'b0, "R10 out_last after reset", {63'd0, out_last}, 64'd0);
        check(in_ready === 1'b1, "R10 in_ready after reset", {63'd0, in_ready}, 64'd1);
        @(posedge clk);
        #2;
    endtask

    task automatic test_corners();
        clear_marks();
        rdy_mode = 0;
        send_word(32'h0000_0000, 1'b0); // 0
        send_word(32'h0004_0003, 1'b0); // 3,4 -> 5
        send_word(32'h0000_FFFF, 1'b0); // -1,0 -> 1
        send_word(32'h8000_8000, 1'b0); // extreme
        send_word(32'h0002_0002, 1'b0); // sqrt 8 -> 2
        send_word(32'h7FFF_7FFF, 1'b0); // 46339
        send_word(32'hFFFB_0000, 1'b1); // 0,-5 -> 5
        idle();
        drain();
        check(out_log.size() == 7, "R5 corner count", 64'(out_log.size()), 64'd7);
        if (out_log.size() == 7) begin
            check(out_log[0] == 32'h0000_0000, "R3 zero bin", {32'd0, out_log[0]}, 64'h0);
            check(out_log[1] == 32'h40A0_0000, "R4 five", {32'd0, out_log[1]}, 64'h40A0_0000);
            check(out_log[2] == 32'h3F80_0000, "R1 signed real -1", {32'd0, out_log[2]}, 64'h3F80_0000);
            check(out_log[3] == 32'h4735_0400, "R2 extreme halves", {32'd0, out_log[3]}, 64'h4735_0400);
            check(out_log[4] == 32'h4000_0000, "R2 floor of root", {32'd0, out_log[4]}, 64'h4000_0000);
            check(out_log[5] == 32'h4735_0300, "R4 wide root", {32'd0, out_log[5]}, 64'h4735_0300);
            check(out_log[6] == 32'h40A0_0000, "R1 signed imaginary", {32'd0, out_log[6]}, 64'h40A0_0000);
        end
        check(last_cnt == 1 && last_idx == 6, "R6 corner last position", 64'(last_idx), 64'd6);
    endtask

    task automatic test_latency();
        clear_marks();
        rdy_mode = 0;
        @(posedge clk);
        #2;
        for (int i = 0; i < 32; i++) begin
            dgen = dgen * 32'd1664525 + 32'd1013904223;
            send_word(dgen, i == 31);
        end
        idle();
        drain();
        check(first_out_cyc - first_in_cyc == DEPTH, "R9 latency",
              64'(first_out_cyc - first_in_cyc), 64'(DEPTH));
        check(last_out_cyc - first_out_cyc + 1 == 32, "R9 one bin per clock",
              64'(last_out_cyc - first_out_cyc + 1), 64'd32);
    endtask

    task automatic test_frame();
        clear_marks();
        rdy_mode = 1;
        for (int i = 0; i < FRAME; i++) begin
            dgen = dgen * 32'd1664525 + 32'd1013904223;
            send_word(dgen ^ {dgen[7:0], 24'd0}, i == FRAME - 1);
        end
        idle();
        rdy_mode = 0;
        drain();
        check(out_cnt == FRAME, "R5 frame beat count", 64'(out_cnt), 64'(FRAME));
        check(last_cnt == 1 && last_idx == FRAME - 1, "R6 frame last position",
              64'(last_idx), 64'(FRAME - 1));
    endtask

    task automatic test_full_stall();
        int acc;
        clear_marks();
        rdy_mode = 2;
        @(posedge clk);
        #2;
        acc = 0;
        in_valid = 1'b1;
        in_last  = 1'b0;
        for (int i = 0; i < 30; i++) begin
            dgen = dgen * 32'd1664525 + 32'd1013904223;
            in_data = dgen;
            @(negedge clk);
            if (in_ready) acc++;
            @(posedge clk);
            #2;
        end
        idle();
        check(acc == DEPTH, "R8 bins taken while stalled", 64'(acc), 64'(DEPTH));
        @(negedge clk);
        check(in_ready === 1'b0, "R8 in_ready when full", {63'd0, in_ready}, 64'd0);
        check(out_valid === 1'b1, "R7 output held while stalled", {63'd0, out_valid}, 64'd1);
        @(posedge clk);
        #2;
        rdy_mode = 0;
        drain();
        check(out_cnt == DEPTH, "R5 stalled bins delivered", 64'(out_cnt), 64'(DEPTH));
    endtask

    task automatic test_reset_midflight();
        rdy_mode = 2;
        @(posedge clk);
        #2;
        for (int i = 0; i < 5; i++) send_word(32'h0004_0003, 1'b1);
        idle();
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        exp_q.delete();
        held = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R10 valid cleared by reset", {63'd0, out_valid}, 64'd0);
        check(out_last === 1'b0, "R10 last cleared by reset", {63'd0, out_last}, 64'd0);
        check(in_ready === 1'b1, "R10 ready after mid reset", {63'd0, in_ready}, 64'd1);
        rdy_mode = 0;
        repeat (DEPTH + 2) @(negedge clk);
        check(out_valid === 1'b0, "R10 no stale bins after reset", {63'd0, out_valid}, 64'd0);
        @(posedge clk);
        #2;
    endtask

    initial begin
        test_reset();
        test_corners();
        test_latency();
        test_full_stall();
        test_frame();
        test_reset_midflight();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule